// File: doc/BRIEF.md
# Quad-Pumped Source-Synchronous Data Receiver

This block receives a 64-bit data bus that moves four transfers in each common clock period. The bus is cut into four 16-bit lanes, and each lane carries its own pair of data strobes. Lane k drives bits 16k+15 down to 16k and uses strobe pair k. On every falling strobe edge a lane samples its 16 wires. The two strobes of a pair take turns: the first strobe of the pair takes transfers 0 and 2, and the second takes transfers 1 and 3. Each lane also has one inversion flag per transfer, which tells the receiver that the sender flipped that lane's bits. The receiver flips them back.

All wires are active low. After its fourth transfer, a lane pushes the 64 bits it gathered into its own small FIFO. That FIFO moves the data from the strobe domain into the common clock domain. Once all four lane FIFOs hold a complete quad-word, the block pops one entry from each. It merges them into a 256-bit word and raises a valid for a single clock.

Top module: `qp_data_rx`

## Requirements
- R1: For transfer t (0..3), lane k's recovered 16 bits appear at `qword_o[64t+16k +: 16]`. Transfers 0 and 2 are taken on falling edges of `strb_a_n[k]`, and transfers 1 and 3 on falling edges of `strb_b_n[k]`, in the order A, B, A, B.
- R2: When a lane's inversion flag wire is high (flag inactive), a low data wire gives logical 1 and a high data wire gives logical 0.
- R3: When a lane's inversion flag wire is low (flag active) during a transfer, that lane's recovered bits equal the data wire levels unchanged.
- R4: An inversion flag affects only its own lane and only the transfer it was sampled with.
- R5: `qword_vld_o` is high for exactly one clock per delivered quad-word. It never goes high while any lane still lacks a complete quad-word. `qword_o` changes only together with a valid.
- R6: Each lane buffers at least two (by default four) complete quad-words. The quad-words are delivered in the order they were received.
- R7: While `rst_n` is low, `qword_vld_o` is 0 and `qword_o` is all zeros. Transfers received before a reset are discarded, and the next falling edge of the A strobe is taken as transfer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_a_n | input | 4 | Per-lane strobe that samples transfers 0 and 2 on its falling edge |
| strb_b_n | input | 4 | Per-lane strobe that samples transfers 1 and 3 on its falling edge |
| data_n | input | 64 | Active-low data wires, lane k on bits 16k+15:16k |
| inv_n | input | 4 | Active-low per-lane inversion flags, bit k for lane k |
| qword_o | output | 256 | Assembled quad-word, transfer t lane k at bits 64t+16k+15:64t+16k |
| qword_vld_o | output | 1 | Single-cycle valid for `qword_o` |

## Verification
A pattern that is distinct for every lane and transfer catches a swapped strobe, a swapped slot or a wrong lane position. All-ones and all-zeros data with the flags inactive show the active-low mapping. All flags active, and then a mix of flags that varies by lane and by transfer, separate lane-local inversion from inversion that leaks into other lanes or other transfers. Three further cases cover the remaining rules:
- Feeding two quad-words to three lanes while the fourth stays idle, then feeding the fourth lane, shows that no valid is raised early, that lanes can buffer in depth, and that quad-words keep their order.
- Back-to-back quad-words test the buffering under sustained traffic.
- A reset in the middle of a quad-word checks that the partial transfers are discarded and that counting starts again from transfer 0.

// File: rtl/qp_rx_pkg.sv
`timescale 1ns/1ps
package qp_rx_pkg;
  // transfers carried per lane in one common clock period
  localparam int unsigned XFERS = 4;

  // which of the two falling edges of a strobe comes next
  typedef enum logic {
    EDGE_FIRST  = 1'b0,
    EDGE_SECOND = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/qp_rst_sync.sv
`timescale 1ns/1ps
module qp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] shift_q;
  logic [1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[1];
endmodule

// File: rtl/qp_lane_cap.sv
`timescale 1ns/1ps
module qp_lane_cap
  import qp_rx_pkg::*;
#(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned LQ_W = XFERS * LANE_W
) (
  input  logic              strb_a_n,
  input  logic              strb_b_n,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] data_n,
  input  logic              inv_n,
  output logic              wr_en_o,
  output logic [LQ_W-1:0]   wr_data_o
);
  logic [LANE_W-1:0] true_bits;
  edge_sel_e         a_sel_q, a_sel_d;
  edge_sel_e         b_sel_q, b_sel_d;
  logic [LANE_W-1:0] slot0_q, slot1_q, slot2_q;

  // flag inactive (high) -> complement wires; flag active (low) -> wires as-is
  always_comb begin
    true_bits = data_n ^ {LANE_W{inv_n}};
  end

  always_comb begin
    a_sel_d = (a_sel_q == EDGE_FIRST) ? EDGE_SECOND : EDGE_FIRST;
    b_sel_d = (b_sel_q == EDGE_FIRST) ? EDGE_SECOND : EDGE_FIRST;
  end

  always_ff @(negedge strb_a_n or negedge rst_n) begin
    if (!rst_n) a_sel_q <= EDGE_FIRST;
    else        a_sel_q <= a_sel_d;
  end

  always_ff @(negedge strb_b_n or negedge rst_n) begin
    if (!rst_n) b_sel_q <= EDGE_FIRST;
    else        b_sel_q <= b_sel_d;
  end

  // data slots carry no reset
  always_ff @(negedge strb_a_n) begin
    if (a_sel_q == EDGE_FIRST)  slot0_q <= true_bits;
    if (a_sel_q == EDGE_SECOND) slot2_q <= true_bits;
  end

  always_ff @(negedge strb_b_n) begin
    if (b_sel_q == EDGE_FIRST) slot1_q <= true_bits;
  end

  // transfer 3 arrives with the second B edge and is written straight through
  assign wr_en_o   = (b_sel_q == EDGE_SECOND);
  assign wr_data_o = {true_bits, slot2_q, slot1_q, slot0_q};

  // R1
  strobe_order_chk: assert property (@(negedge strb_b_n) disable iff (!rst_n)
    a_sel_q != b_sel_q);
endmodule

// File: rtl/qp_lane_fifo.sv
`timescale 1ns/1ps
module qp_lane_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic         wstrb_n,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_avail
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];

  // write side, clocked by falling strobe
  logic [PW-1:0] wbin_q, wbin_d, wgray_q;
  logic [PW-1:0] rgray_w1_q, rgray_w2_q;
  logic [PW-1:0] rbin_seen;
  logic          full, do_wr;

  // read side, common clock
  logic [PW-1:0] rbin_q, rbin_d, rgray_q;
  logic [PW-1:0] wgray_r1_q, wgray_r2_q;
  logic [PW-1:0] wbin_seen;

  always_comb begin
    rbin_seen = from_gray(rgray_w2_q);
    full      = (wbin_q - rbin_seen) == PW'(DEPTH);
    do_wr     = wr_en & ~full;
    wbin_d    = do_wr ? wbin_q + 1'b1 : wbin_q;
  end

  always_ff @(negedge wstrb_n or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      rgray_w1_q <= '0;
      rgray_w2_q <= '0;
    end else begin
      wbin_q     <= wbin_d;
      wgray_q    <= to_gray(wbin_d);
      rgray_w1_q <= rgray_q;
      rgray_w2_q <= rgray_w1_q;
    end
  end

  always_ff @(negedge wstrb_n) begin
    if (do_wr) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  always_comb begin
    wbin_seen = from_gray(wgray_r2_q);
    rd_avail  = (wgray_r2_q != rgray_q);
    rd_data   = mem[rbin_q[AW-1:0]];
    rbin_d    = rd_en ? rbin_q + 1'b1 : rbin_q;
  end

  always_ff @(posedge clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      wgray_r1_q <= '0;
      wgray_r2_q <= '0;
    end else begin
      rbin_q     <= rbin_d;
      rgray_q    <= to_gray(rbin_d);
      wgray_r1_q <= wgray_q;
      wgray_r2_q <= wgray_r1_q;
    end
  end

  // R6
  gray_step_chk: assert property (@(posedge clk) disable iff (!rrst_n)
    $countones(wgray_r2_q ^ $past(wgray_r2_q)) <= 1);

  // R6
  occupancy_chk: assert property (@(posedge clk) disable iff (!rrst_n)
    (wbin_seen - rbin_q) <= PW'(DEPTH));

  // R5
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rrst_n)
    rd_en |-> rd_avail);
endmodule

// File: rtl/qp_data_rx.sv
`timescale 1ns/1ps
module qp_data_rx
  import qp_rx_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned BUS_W = LANES * LANE_W,
  localparam int unsigned LQ_W  = XFERS * LANE_W,
  localparam int unsigned QW    = XFERS * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] strb_a_n,
  input  logic [LANES-1:0] strb_b_n,
  input  logic [BUS_W-1:0] data_n,
  input  logic [LANES-1:0] inv_n,
  output logic [QW-1:0]    qword_o,
  output logic             qword_vld_o
);
  logic             rst_s_n;
  logic [LANES-1:0] lane_avail;
  logic [LQ_W-1:0]  lane_rd [LANES];
  logic             pop;
  logic [QW-1:0]    merged;
  logic [QW-1:0]    qword_q, qword_d;
  logic             vld_q, vld_d;

  qp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic            wr_en;
    logic [LQ_W-1:0] wr_data;

    qp_lane_cap #(.LANE_W(LANE_W)) u_cap (
      .strb_a_n  (strb_a_n[k]),
      .strb_b_n  (strb_b_n[k]),
      .rst_n     (rst_n),
      .data_n    (data_n[k*LANE_W +: LANE_W]),
      .inv_n     (inv_n[k]),
      .wr_en_o   (wr_en),
      .wr_data_o (wr_data)
    );

    qp_lane_fifo #(.W(LQ_W), .DEPTH(DEPTH)) u_fifo (
      .wstrb_n  (strb_b_n[k]),
      .wrst_n   (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .clk      (clk),
      .rrst_n   (rst_s_n),
      .rd_en    (pop),
      .rd_data  (lane_rd[k]),
      .rd_avail (lane_avail[k])
    );
  end

  assign pop = &lane_avail;

  always_comb begin
    merged = '0;
    for (int t = 0; t < XFERS; t++) begin
      for (int k = 0; k < LANES; k++) begin
        merged[t*BUS_W + k*LANE_W +: LANE_W] = lane_rd[k][t*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    qword_d = pop ? merged : qword_q;
    vld_d   = pop;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      qword_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      qword_q <= qword_d;
      vld_q   <= vld_d;
    end
  end

  assign qword_o     = qword_q;
  assign qword_vld_o = vld_q;

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(qword_o) |-> qword_vld_o);
endmodule

// File: tb/test_qp_data_rx.sv
`timescale 1ns/1ps
module test_qp_data_rx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   sa = '1;
  logic [3:0]   sb = '1;
  logic [63:0]  dn = '1;
  logic [3:0]   invn = '1;
  logic [255:0] qword;
  logic         vld;

  int checks = 0;
  int fails = 0;
  int ngot = 0;
  logic [255:0] got [32];
  bit done = 1'b0;

  always #5 clk = ~clk;

  qp_data_rx i_qp_data_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb_a_n    (sa),
    .strb_b_n    (sb),
    .data_n      (dn),
    .inv_n       (invn),
    .qword_o     (qword),
    .qword_vld_o (vld)
  );

  always @(negedge clk) begin
    if (vld === 1'b1 && ngot < 32) begin
      got[ngot] = qword;
      ngot++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] pat(input int seed);
    logic [255:0] w;
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 4; k++)
        w[t*64 + k*16 +: 16] = 16'(seed * 16'h1357 + t * 16'h0110 + k * 16'h2002) ^ 16'hA5C3;
    return w;
  endfunction

  // inv bit t*4+k set = flag active for lane k at transfer t
  task automatic drive_qword(input logic [255:0] tw, input logic [15:0] inv,
                             input logic [3:0] lanes, input int nx);
    for (int t = 0; t < nx; t++) begin
      for (int k = 0; k < 4; k++) begin
        if (lanes[k]) begin
          invn[k] = ~inv[t*4 + k];
          dn[k*16 +: 16] = inv[t*4 + k] ? tw[t*64 + k*16 +: 16] : ~tw[t*64 + k*16 +: 16];
        end
      end
      #1;
      if (t % 2 == 0) sa = sa & ~lanes;
      else            sb = sb & ~lanes;
      #1;
      sa = '1;
      sb = '1;
      #0.5;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic settle();
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic expect_words(input int n0, input logic [255:0] w, input string req);
    chk(ngot == n0 + 1, {req, "_count"}, 256'(ngot), 256'(n0 + 1));
    chk(got[n0] === w, req, got[n0], w);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk(vld === 1'b0, "R7_vld", 256'(vld), 256'd0);
    chk(qword === '0, "R7_word", qword, '0);
  endtask

  task automatic t_layout();
    int n0 = ngot;
    logic [255:0] w = pat(1);
    drive_qword(w, 16'h0000, 4'hF, 4);
    settle();
    // R1 lane/transfer placement, R5 single pulse
    expect_words(n0, w, "R1");
  endtask

  task automatic t_polarity();
    int n0 = ngot;
    drive_qword('1, 16'h0000, 4'hF, 4);
    settle();
    expect_words(n0, '1, "R2_ones");
    n0 = ngot;
    drive_qword('0, 16'h0000, 4'hF, 4);
    settle();
    expect_words(n0, '0, "R2_zeros");
  endtask

  task automatic t_all_inverted();
    int n0 = ngot;
    logic [255:0] w = pat(3);
    drive_qword(w, 16'hFFFF, 4'hF, 4);
    settle();
    expect_words(n0, w, "R3");
  endtask

  task automatic t_mixed_inv();
    int n0 = ngot;
    logic [255:0] w = pat(4);
    drive_qword(w, 16'hA53C, 4'hF, 4);
    settle();
    expect_words(n0, w, "R4");
  endtask

  task automatic t_lane_stall();
    int n0 = ngot;
    logic [255:0] w1 = pat(5);
    logic [255:0] w2 = pat(6);
    drive_qword(w1, 16'h0000, 4'h7, 4);
    drive_qword(w2, 16'h1248, 4'h7, 4);
    settle();
    // R5 no valid while lane 3 has nothing
    chk(ngot == n0, "R5_wait", 256'(ngot), 256'(n0));
    drive_qword(w1, 16'h0000, 4'h8, 4);
    drive_qword(w2, 16'h1248, 4'h8, 4);
    settle();
    chk(ngot == n0 + 2, "R6_count", 256'(ngot), 256'(n0 + 2));
    chk(got[n0] === w1, "R6_first", got[n0], w1);
    chk(got[n0 + 1] === w2, "R6_second", got[n0 + 1], w2);
  endtask

  task automatic t_back_to_back();
    int n0 = ngot;
    for (int i = 0; i < 3; i++) drive_qword(pat(10 + i), 16'(i * 16'h0F0F), 4'hF, 4);
    settle();
    chk(ngot == n0 + 3, "R6_b2b_count", 256'(ngot), 256'(n0 + 3));
    for (int i = 0; i < 3; i++)
      chk(got[n0 + i] === pat(10 + i), "R6_b2b", got[n0 + i], pat(10 + i));
  endtask

  task automatic t_reset_mid();
    int n0;
    drive_qword(pat(7), 16'h0000, 4'hF, 2);
    do_reset();
    @(negedge clk);
    chk(vld === 1'b0, "R7_mid_vld", 256'(vld), 256'd0);
    chk(qword === '0, "R7_mid_word", qword, '0);
    n0 = ngot;
    drive_qword(pat(8), 16'h00F0, 4'hF, 4);
    settle();
    expect_words(n0, pat(8), "R7_restart");
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_layout();
    t_polarity();
    t_all_inverted();
    t_mixed_inv();
    t_lane_stall();
    t_back_to_back();
    t_reset_mid();
    done = 1'b1;
    report();
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end
endmodule